// File: doc/BRIEF.md
# Bidirectional 8-bit Timer Counter

This block holds an 8-bit count that is cleared, incremented or decremented once for each enabled timer tick. A 3-bit clock-select field gates the tick. The tick comes from a free-running prescaler or, when the source-select input is high, from a single-cycle enable pulse supplied from outside. Both are synchronous to the one system clock. A 3-bit waveform mode field sets the direction and the shape of the count sequence. It also sets the upper turning point: either the fixed maximum 0xFF or the value on the compare-A input.

The host can load the count at any cycle and can always read it. A host load takes precedence over the tick in that cycle. The block drives two indicators: one shows that the count sits at the current upper turning point, the other shows that it sits at zero. It keeps a sticky overflow flag that is set at a point fixed by the mode. The flag is cleared either by a write-one strobe or by an interrupt-acknowledge pulse. The interrupt request is the flag gated by a mask input.

Top module: `bidir_timer8`

## Requirements
- R1: After reset the count is 0x00, the overflow flag is 0 and the stored direction is up.
- R2: With clkSel = 0 no tick occurs: the count holds and the overflow flag is not set.
- R3: The prescaler is a 10-bit counter that is 0 after reset and steps once per clock. With srcExt = 0, the codes clkSel 1..7 give one tick every 1, 8, 32, 64, 128, 256 and 1024 clocks. A tick occurs in the cycle where the low log2(ratio) prescaler bits are all ones. With srcExt = 1 and clkSel non-zero, extTick is the tick.
- R4: When cntWrEn is high, the count takes cntWrData at the next edge, whether or not a tick occurs. The overflow flag is not set in that cycle, and cntRdData always shows the count.
- R5: Modes 0 and 3, and the unused codes 4 and 6, count up with a top of 0xFF. A tick at 0xFF gives 0x00 and sets the overflow flag.
- R6: In mode 2 the top is topValA. A tick while the count equals topValA gives 0x00, otherwise it gives count+1. The overflow flag is set by a tick at 0xFF.
- R7: In mode 7 the top is topValA. A tick at topValA gives 0x00 and sets the overflow flag, otherwise it gives count+1 (0xFF wraps to 0 without setting the flag).
- R8: Modes 1 (top 0xFF) and 5 (top topValA) count up and down. On a tick at 0x00 the direction becomes up, the flag is set, and the count goes to 1, or stays at 0 when the top is 0. On a tick at or above a non-zero top the direction becomes down and the count decrements. Otherwise the count steps in the stored direction.
- R9: atBottom is high exactly when the count is 0x00. atTop is high exactly when the count equals the mode's top (topValA in modes 2, 5 and 7, 0xFF in the others).
- R10: The overflow flag is cleared by ovfWrEn with ovfWrBit = 1, or by intAck. A set in the same cycle wins over a clear. irq = ovfFlag AND ovfMask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| clkSel | input | 3 | Tick source: 0 stopped, 1..7 prescale ratios |
| srcExt | input | 1 | Take the tick from extTick instead of the prescaler |
| extTick | input | 1 | External single-cycle tick enable |
| waveMode | input | 3 | Count sequence mode |
| topValA | input | 8 | Compare-A value used as top in modes 2, 5, 7 |
| cntWrEn | input | 1 | Host write strobe for the count |
| cntWrData | input | 8 | Host write data for the count |
| cntRdData | output | 8 | Current count |
| atTop | output | 1 | Count equals current top |
| atBottom | output | 1 | Count equals zero |
| ovfWrEn | input | 1 | Host write strobe for the flag bit |
| ovfWrBit | input | 1 | Written flag bit value (1 clears) |
| intAck | input | 1 | Interrupt acknowledge pulse, clears the flag |
| ovfMask | input | 1 | Interrupt mask |
| ovfFlag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Interrupt request |

## Verification
The wrap and single-step properties take every strobe input to be a clean level sampled at the clock. They also take the prescaler ratio 1 tick to be present in every cycle. In dual-slope modes they assume the count moves by at most one per cycle, and only a host load or a clear may break that. The stimulus drives every input just after the falling edge, so no input changes near the sampling edge. Host loads are kept rare, and mode, clock-select and source fields change only every few dozen cycles, so long runs in each mode reach their turning points and wraps. Directed sequences cover a top of zero in dual slope, a load at 0xFF in the same cycle as a tick, and a flag set that coincides with a clear.

// File: rtl/bidir_timer8_pkg.sv
package bidir_timer8_pkg;

  typedef enum logic [2:0] {
    MODE_WRAP     = 3'd0,
    MODE_TRI_MAX  = 3'd1,
    MODE_CLR_A    = 3'd2,
    MODE_FAST_MAX = 3'd3,
    MODE_RSV4     = 3'd4,
    MODE_TRI_A    = 3'd5,
    MODE_RSV6     = 3'd6,
    MODE_FAST_A   = 3'd7
  } waveMode_e;

  // Strobes from control to datapath for one clock.
  typedef struct packed {
    logic load;
    logic inc;
    logic dec;
    logic clr;
    logic setDir;
    logic dirVal;
    logic setOvf;
  } ctlCmd_t;

endpackage

// File: rtl/bt8_tick_gen.sv
module bt8_tick_gen #(
  parameter int PRE_W = 10,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] clkSel,
  input  logic             srcExt,
  input  logic             extTick,
  output logic             tick
);
  localparam int RATIO_N = (1 << SEL_W) - 1;

  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] divMask;
  logic             preTick;

  always_ff @(posedge clk) begin
    if (!rstN) preCnt <= '0;
    else       preCnt <= preCnt + 1'b1;
  end

  // Mask of prescaler bits that must all be ones for a tick.
  always_comb begin
    case (clkSel)
      3'd1:    divMask = PRE_W'(0);
      3'd2:    divMask = PRE_W'(7);
      3'd3:    divMask = PRE_W'(31);
      3'd4:    divMask = PRE_W'(63);
      3'd5:    divMask = PRE_W'(127);
      3'd6:    divMask = PRE_W'(255);
      default: divMask = PRE_W'(1023);
    endcase
  end

  assign preTick = ((preCnt & divMask) == divMask);
  assign tick    = (clkSel != '0) && (srcExt ? extTick : preTick);

  // R3: ratio 1 from the prescaler ticks every cycle
  p_div1_r3: assert property (@(posedge clk) disable iff (!rstN)
    (clkSel == SEL_W'(1) && !srcExt) |-> tick);

  // R2: a stopped source never ticks
  p_stop_r2: assert property (@(posedge clk) disable iff (!rstN)
    (clkSel == '0) |-> !tick);

  initial begin
    if (RATIO_N != 7) $display("bt8_tick_gen: select width not 3");
  end
endmodule

// File: rtl/bt8_ctrl.sv
module bt8_ctrl
  import bidir_timer8_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic [2:0]       waveMode,
  input  logic [CNT_W-1:0] topValA,
  input  logic             tick,
  input  logic             cntWrEn,
  input  logic [CNT_W-1:0] cnt,
  input  logic             dirDown,
  output logic [CNT_W-1:0] topVal,
  output ctlCmd_t          cmd
);
  localparam logic [CNT_W-1:0] MAXV = '1;

  waveMode_e mode;
  logic      dualSlope;

  assign mode      = waveMode_e'(waveMode);
  assign dualSlope = (mode == MODE_TRI_MAX) || (mode == MODE_TRI_A);

  always_comb begin
    case (mode)
      MODE_CLR_A, MODE_TRI_A, MODE_FAST_A: topVal = topValA;
      default:                             topVal = MAXV;
    endcase
  end

  always_comb begin
    cmd = '0;
    if (cntWrEn) begin
      cmd.load = 1'b1;
    end else if (tick) begin
      if (dualSlope) begin
        if (cnt == '0) begin
          cmd.setOvf = 1'b1;
          cmd.setDir = 1'b1;
          cmd.dirVal = 1'b0;
          cmd.inc    = (topVal != '0);
        end else if (cnt >= topVal) begin
          cmd.setDir = 1'b1;
          cmd.dirVal = 1'b1;
          cmd.dec    = 1'b1;
        end else begin
          cmd.dec = dirDown;
          cmd.inc = !dirDown;
        end
      end else if (mode == MODE_CLR_A) begin
        cmd.setOvf = (cnt == MAXV);
        cmd.clr    = (cnt == topVal);
        cmd.inc    = (cnt != topVal);
      end else if (mode == MODE_FAST_A) begin
        cmd.setOvf = (cnt == topVal);
        cmd.clr    = (cnt == topVal);
        cmd.inc    = (cnt != topVal);
      end else begin
        cmd.setOvf = (cnt == MAXV);
        cmd.inc    = 1'b1;
      end
    end
  end

  // R4: a host load excludes every count operation
  always_comb begin
    if (cmd.load) begin
      p_load_excl_r4: assert (!cmd.inc && !cmd.dec && !cmd.clr && !cmd.setOvf);
    end
  end
endmodule

// File: rtl/bt8_datapath.sv
module bt8_datapath
  import bidir_timer8_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlCmd_t          cmd,
  input  logic [CNT_W-1:0] wrData,
  input  logic             flagClr,
  output logic [CNT_W-1:0] cnt,
  output logic             dirDown,
  output logic             ovfFlag
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt     <= '0;
      dirDown <= 1'b0;
      ovfFlag <= 1'b0;
    end else begin
      if (cmd.load)     cnt <= wrData;
      else if (cmd.clr) cnt <= '0;
      else if (cmd.inc) cnt <= cnt + 1'b1;
      else if (cmd.dec) cnt <= cnt - 1'b1;
      if (cmd.setDir) dirDown <= cmd.dirVal;
      if (cmd.setOvf)      ovfFlag <= 1'b1;
      else if (flagClr)    ovfFlag <= 1'b0;
    end
  end

  // R10: set wins over a coincident clear
  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rstN)
    cmd.setOvf |=> ovfFlag);

  // R10: a clear without set drops the flag
  p_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    (flagClr && !cmd.setOvf) |=> !ovfFlag);

  // R8: without load or clear the count moves by at most one
  p_step_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.load && !cmd.clr) |=>
      (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1 || cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/bidir_timer8.sv
module bidir_timer8
  import bidir_timer8_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int PRE_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       clkSel,
  input  logic             srcExt,
  input  logic             extTick,
  input  logic [2:0]       waveMode,
  input  logic [CNT_W-1:0] topValA,
  input  logic             cntWrEn,
  input  logic [CNT_W-1:0] cntWrData,
  output logic [CNT_W-1:0] cntRdData,
  output logic             atTop,
  output logic             atBottom,
  input  logic             ovfWrEn,
  input  logic             ovfWrBit,
  input  logic             intAck,
  input  logic             ovfMask,
  output logic             ovfFlag,
  output logic             irq
);
  logic             tick;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] topVal;
  logic             dirDown;
  ctlCmd_t          cmd;

  bt8_tick_gen #(.PRE_W(PRE_W), .SEL_W(3)) tick_i (
    .clk(clk), .rstN(rstN), .clkSel(clkSel), .srcExt(srcExt),
    .extTick(extTick), .tick(tick)
  );

  bt8_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .waveMode(waveMode), .topValA(topValA), .tick(tick), .cntWrEn(cntWrEn),
    .cnt(cnt), .dirDown(dirDown), .topVal(topVal), .cmd(cmd)
  );

  bt8_datapath #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .cmd(cmd), .wrData(cntWrData),
    .flagClr((ovfWrEn && ovfWrBit) || intAck),
    .cnt(cnt), .dirDown(dirDown), .ovfFlag(ovfFlag)
  );

  assign cntRdData = cnt;
  assign atTop     = (cnt == topVal);
  assign atBottom  = (cnt == '0);
  assign irq       = ovfFlag && ovfMask;

  // R4: a host load lands on the next edge
  p_wr_prio_r4: assert property (@(posedge clk) disable iff (!rstN)
    cntWrEn |=> (cntRdData == $past(cntWrData)));

  // R2: stopped clock holds the count
  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (clkSel == 3'd0 && !cntWrEn) |=> (cntRdData == $past(cntRdData)));

  // R5: wrap from max with a tick every cycle
  p_wrap_r5: assert property (@(posedge clk) disable iff (!rstN)
    (waveMode == 3'd0 && clkSel == 3'd1 && !srcExt && !cntWrEn && cntRdData == '1)
      |=> (cntRdData == '0 && ovfFlag));
endmodule

// File: tb/bidir_timer8_tb_top.sv
module bidir_timer8_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] clkSel = '0;
  logic srcExt = 1'b0, extTick = 1'b0;
  logic [2:0] waveMode = '0;
  logic [7:0] topValA = '0;
  logic cntWrEn = 1'b0;
  logic [7:0] cntWrData = '0;
  logic [7:0] cntRdData;
  logic atTop, atBottom;
  logic ovfWrEn = 1'b0, ovfWrBit = 1'b0, intAck = 1'b0, ovfMask = 1'b0;
  logic ovfFlag, irq;

  int nChecks = 0, nFails = 0;
  bit done = 0;

  // model state
  int mCnt, mPre;
  bit mDown, mFlag;

  always #(CLK_PERIOD/2) clk = ~clk;

  bidir_timer8 dut_i (
    .clk(clk), .rstN(rstN), .clkSel(clkSel), .srcExt(srcExt), .extTick(extTick),
    .waveMode(waveMode), .topValA(topValA), .cntWrEn(cntWrEn), .cntWrData(cntWrData),
    .cntRdData(cntRdData), .atTop(atTop), .atBottom(atBottom), .ovfWrEn(ovfWrEn),
    .ovfWrBit(ovfWrBit), .intAck(intAck), .ovfMask(ovfMask), .ovfFlag(ovfFlag), .irq(irq)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int divMask(input int sel);
    case (sel)
      1: return 0;
      2: return (1 << 3) - 1;
      3: return (1 << 5) - 1;
      4: return (1 << 6) - 1;
      5: return (1 << 7) - 1;
      6: return (1 << 8) - 1;
      default: return (1 << 10) - 1;
    endcase
  endfunction

  function automatic int expTop(input int mode, input int a);
    return (mode == 2 || mode == 5 || mode == 7) ? a : 255;
  endfunction

  function automatic string modeReq(input int mode);
    case (mode)
      2: return "R6";
      7: return "R7";
      1, 5: return "R8";
      default: return "R5";
    endcase
  endfunction

  // advance the model over one edge using the inputs now applied
  task automatic modelEdge();
    bit tk, setF;
    int top, m;
    m = int'(waveMode);
    top = expTop(m, int'(topValA));
    tk = (clkSel != 0) && (srcExt ? extTick : ((mPre & divMask(clkSel)) == divMask(clkSel)));
    setF = 0;
    if (cntWrEn) mCnt = int'(cntWrData);
    else if (tk) begin
      if (m == 1 || m == 5) begin
        if (mCnt == 0) begin
          setF = 1; mDown = 0;
          if (top != 0) mCnt = 1;
        end else if (mCnt >= top) begin
          mDown = 1; mCnt = mCnt - 1;
        end else mCnt = mDown ? mCnt - 1 : mCnt + 1;
      end else if (m == 2) begin
        setF = (mCnt == 255);
        mCnt = (mCnt == top) ? 0 : (mCnt + 1) % 256;
      end else if (m == 7) begin
        setF = (mCnt == top);
        mCnt = (mCnt == top) ? 0 : (mCnt + 1) % 256;
      end else begin
        setF = (mCnt == 255);
        mCnt = (mCnt + 1) % 256;
      end
    end
    if (setF) mFlag = 1;
    else if ((ovfWrEn && ovfWrBit) || intAck) mFlag = 0;
    mPre = (mPre + 1) % 1024;
  endtask

  task automatic checkAll(input string req);
    chk(req, "count", int'(cntRdData), mCnt);
    chk("R10", "flag", int'(ovfFlag), int'(mFlag));
    chk("R10", "irq", int'(irq), int'(mFlag && ovfMask));
    chk("R9", "atBottom", int'(atBottom), int'(mCnt == 0));
    chk("R9", "atTop", int'(atTop), int'(mCnt == expTop(int'(waveMode), int'(topValA))));
  endtask

  task automatic step(input string req);
    modelEdge();
    @(negedge clk);
    cntWrEn = 0; extTick = 0; ovfWrEn = 0; intAck = 0;
    checkAll(req);
  endtask

  task automatic load(input int v);
    cntWrEn = 1; cntWrData = 8'(v);
    step("R4");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int held;
    void'($urandom(32'd1357));
    mCnt = 0; mPre = 0; mDown = 0; mFlag = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    chk("R1", "count", int'(cntRdData), 0);
    chk("R1", "flag", int'(ovfFlag), 0);

    // R2: stopped
    waveMode = 0; clkSel = 0;
    load(37);
    held = int'(cntRdData);
    for (int i = 0; i < 20; i++) step("R2");
    chk("R2", "held count", int'(cntRdData), held);

    // R5 wrap, R4 write beats tick at 0xFF
    clkSel = 1;
    load(254);
    step("R5"); step("R5");
    chk("R5", "flag after wrap", int'(ovfFlag), 1);
    ovfWrEn = 1; ovfWrBit = 1; step("R10");
    load(255);
    load(9);
    chk("R4", "load over tick", int'(cntRdData), 9);
    chk("R4", "no flag on load", int'(ovfFlag), 0);

    // R10 set wins over clear
    load(255);
    intAck = 1; step("R10");
    chk("R10", "set beats ack", int'(ovfFlag), 1);
    intAck = 1; step("R10");
    chk("R10", "ack clears", int'(ovfFlag), 0);

    // R6 clear on A
    waveMode = 2; topValA = 5; load(3);
    for (int i = 0; i < 8; i++) step("R6");
    // R7 top A
    waveMode = 7; topValA = 4;
    for (int i = 0; i < 12; i++) step("R7");
    // R8 dual slope top 0 and top A
    waveMode = 5; topValA = 0; load(0);
    for (int i = 0; i < 4; i++) step("R8");
    chk("R8", "hold at zero top", int'(cntRdData), 0);
    topValA = 3;
    for (int i = 0; i < 14; i++) step("R8");
    waveMode = 1; load(250);
    for (int i = 0; i < 12; i++) step("R8");

    // R3 prescale ratios and external tick
    waveMode = 0;
    for (int s = 1; s < 8; s++) begin
      clkSel = 3'(s);
      for (int i = 0; i < 80; i++) step("R3");
    end
    srcExt = 1; clkSel = 4;
    for (int i = 0; i < 60; i++) begin
      extTick = 1'($urandom_range(0, 1));
      step("R3");
    end
    srcExt = 0;

    // random mix
    for (int i = 0; i < 6000; i++) begin
      if (i % 60 == 0) begin
        waveMode = 3'($urandom_range(0, 7));
        clkSel = 3'($urandom_range(0, 3));
        srcExt = ($urandom_range(0, 3) == 0);
        topValA = 8'($urandom_range(0, 255));
        ovfMask = 1'($urandom_range(0, 1));
      end
      extTick = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 99) < 2) begin cntWrEn = 1; cntWrData = 8'($urandom_range(0, 255)); end
      if ($urandom_range(0, 99) < 3) begin ovfWrEn = 1; ovfWrBit = 1'($urandom_range(0, 1)); end
      if ($urandom_range(0, 99) < 3) intAck = 1;
      step(modeReq(int'(waveMode)));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule